// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer

This block is an 8-bit timer/counter with one counter shared by three modes. In auto-reload mode it counts up on each count tick and, after 0xFF, starts again from a programmable start value. Each wrap produces a one-cycle overflow strobe. That strobe can drive a pin or clock a serial port's baud generator. In capture mode it counts the same way, and a rising edge on a capture pin copies the running count into a holding register. In frequency-measurement mode it counts rising edges of an external pin during a gate window of a fixed number of reference ticks. At the end of each window it stores the result and starts the next window from zero.

The count tick is either a system-clock-synchronous prescaler strobe or a rising edge of an external clock pin. Both the external clock pin and the capture pin pass through two-flop synchronizers before edge detection. Software uses a small register port: five addresses, synchronous writes and combinational reads. Two sticky event flags feed a single interrupt line through per-flag enables.

Top module: `mtimer8`

## Requirements
- R1: After reset, every register reads 0 (control at address 0, reload at 1, count at 2, capture at 3, status at 4), and both `irq` and `ovf_pulse` are low.
- R2: In auto-reload mode (control bits [2:1] = 0, run bit 0 = 1), each count tick adds one to the count. A tick at count 0xFF loads the reload value instead. Setting the run bit from 0 loads the count from the reload register.
- R3: Each wrap drives `ovf_pulse` high for exactly one cycle and sets status bit 0. That bit stays set until software clears it.
- R4: Writing the reload register while the timer runs leaves the current count untouched. The new value is used only at the next wrap.
- R5: With control bit 3 = 1, the count tick is a rising edge of `ext_clk`, seen after a two-flop synchronizer, and `prescale_tick` has no effect.
- R6: In capture mode (bits [2:1] = 1), a synchronized rising edge of `cap_in` copies the count into the capture register and sets status bit 1. Counting carries on.
- R7: In measurement mode (bits [2:1] = 2), the counter counts synchronized `ext_clk` rising edges. It starts at 0 when run is set. After `GATE_TICKS` prescale ticks the count goes to the capture register, status bit 1 is set and the count restarts at 0.
- R8: In measurement mode the count saturates at 0xFF and produces no overflow strobe.
- R9: `irq` is high while status bit 0 is set with enable bit 4, or status bit 1 is set with enable bit 5.
- R10: Writing a 1 to a status bit clears it. An event in the same cycle wins over the clear.
- R11: With the run bit at 0 the count holds, whatever ticks or edges arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| prescale_tick | input | 1 | Internal prescaled count/reference strobe |
| ext_clk | input | 1 | External clock pin (asynchronous) |
| cap_in | input | 1 | Capture trigger pin (asynchronous) |
| ovf_pulse | output | 1 | One-cycle strobe on each wrap |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check these properties:
- each overflow strobe lands the count on the reload value that was in force one edge earlier;
- the strobe always leaves the overflow flag set;
- that flag never drops without a clear write;
- a stopped counter never moves;
- measurement mode never produces a strobe.

Only the bench scenarios can show the following:
- the count values reached after long random tick runs;
- the deferred effect of a reload write;
- edge counting through the synchronizers;
- the exact window totals, including saturation;
- an event winning over a clear in the same cycle.

// File: rtl/mtimer8.sv
module mtimer8 #(
  parameter int GATE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       prescale_tick,
  input  logic       ext_clk,
  input  logic       cap_in,
  output logic       ovf_pulse,
  output logic       irq
);
  localparam int GW = (GATE_TICKS > 2) ? $clog2(GATE_TICKS) : 1;
  localparam logic [GW-1:0] GATE_LAST = GW'(GATE_TICKS - 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_RLD = 3'd1, A_CNT = 3'd2, A_CAP = 3'd3, A_STAT = 3'd4;
  localparam logic [1:0] M_RELOAD = 2'd0, M_CAPTURE = 2'd1, M_MEASURE = 2'd2;

  logic [5:0]    ctrl_q;
  logic [7:0]    reload_q, cnt_q, cap_q;
  logic [1:0]    flag_q;
  logic [GW-1:0] gate_q;
  logic [2:0]    ext_sync, cap_sync;
  logic          ovf_q;

  wire       run      = ctrl_q[0];
  wire [1:0] mode     = ctrl_q[2:1];
  wire       ext_rise = ext_sync[1] & ~ext_sync[2];
  wire       cap_rise = cap_sync[1] & ~cap_sync[2];
  wire       ctrl_wr  = wr_en && wr_addr == A_CTRL;
  wire       stat_wr  = wr_en && wr_addr == A_STAT;
  wire       start    = ctrl_wr && wr_data[0] && !run;
  wire       tick     = ctrl_q[3] ? ext_rise : prescale_tick;
  wire       counting = run && (mode == M_RELOAD || mode == M_CAPTURE);
  wire       wrap     = counting && tick && cnt_q == 8'hFF;
  wire       measure  = run && mode == M_MEASURE;
  wire       gate_end = measure && prescale_tick && gate_q == GATE_LAST;
  wire       cap_evt  = run && mode == M_CAPTURE && cap_rise;
  wire       meas_inc = ext_rise && cnt_q != 8'hFF;
  wire [1:0] clr_mask = stat_wr ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sync <= '0;
      cap_sync <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_clk};
      cap_sync <= {cap_sync[1:0], cap_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data[5:0];
      if (wr_en && wr_addr == A_RLD) reload_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= (wr_data[2:1] == M_MEASURE) ? 8'h00 : reload_q;
    end else if (counting && tick) begin
      cnt_q <= wrap ? reload_q : cnt_q + 8'd1;
    end else if (gate_end) begin
      cnt_q <= 8'h00;
    end else if (measure && meas_inc) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= '0;
    end else if (ctrl_wr) begin
      gate_q <= '0;
    end else if (measure && prescale_tick) begin
      gate_q <= gate_end ? '0 : gate_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_evt) begin
      cap_q <= cnt_q;
    end else if (gate_end) begin
      cap_q <= meas_inc ? cnt_q + 8'd1 : cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_mask) | {cap_evt | gate_end, wrap};
      ovf_q  <= wrap;
    end
  end

  assign ovf_pulse = ovf_q;
  assign irq       = |(flag_q & ctrl_q[5:4]);

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {2'b00, ctrl_q};
      A_RLD:   rd_data = reload_q;
      A_CNT:   rd_data = cnt_q;
      A_CAP:   rd_data = cap_q;
      A_STAT:  rd_data = {6'b0, flag_q};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/mtimer8_chk.sv
module mtimer8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovf_pulse,
  input logic [7:0] cnt,
  input logic [7:0] reload,
  input logic       run,
  input logic [1:0] mode,
  input logic       ovf_flag,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data
);
  wire clr_ovf = wr_en && wr_addr == 3'd4 && wr_data[0];
  wire ctl_wr  = wr_en && wr_addr == 3'd0;

  p_wrap_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> cnt == $past(reload));

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ovf_flag);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  p_stopped_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctl_wr) |=> $stable(cnt));

  p_measure_no_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == 2'd2 && !ctl_wr) |=> !ovf_pulse);
endmodule

bind mtimer8 mtimer8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse), .cnt(cnt_q), .reload(reload_q),
  .run(ctrl_q[0]), .mode(ctrl_q[2:1]), .ovf_flag(flag_q[0]),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/mtimer8_test.sv
module mtimer8_test;
  localparam int GATE = 8;
  logic clk = 0, rst_n = 0, wr_en = 0, prescale_tick = 0, ext_clk = 0, cap_in = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic ovf_pulse, irq;
  int checks = 0, fails = 0, ovf_seen = 0, seed;
  bit done = 0;

  mtimer8 #(.GATE_TICKS(GATE)) uut (.*);

  always #5 clk = ~clk;
  always @(negedge clk) if (rst_n && ovf_pulse) ovf_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); prescale_tick = 1; end
    @(negedge clk); prescale_tick = 0;
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_clk = 1;
    repeat (2) @(negedge clk); ext_clk = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int model_cnt(int r, int n);
    int c = r;
    for (int i = 0; i < n; i++) c = (c == 255) ? r : c + 1;
    return c;
  endfunction

  function automatic int model_wraps(int r, int n);
    int c = r, w = 0;
    for (int i = 0; i < n; i++) begin
      if (c == 255) begin c = r; w++; end else c++;
    end
    return w;
  endfunction

  initial begin
    int v, r, n, total;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk("R1 reg", v, 0); end
    chk("R1 irq", irq, 0);
    chk("R1 ovf", ovf_pulse, 0);

    // R2/R3 random auto-reload runs
    for (int t = 0; t < 8; t++) begin
      r = $urandom % 256; n = $urandom % 600 + 1;
      wr(0, 8'h00); wr(1, 8'(r)); wr(4, 8'h03);
      ovf_seen = 0;
      wr(0, 8'h01);
      ticks(n);
      @(negedge clk);
      rd(2, v); chk("R2 count", v, model_cnt(r, n));
      chk("R3 pulses", ovf_seen, model_wraps(r, n));
      rd(4, v); chk("R3 flag", v & 1, model_wraps(r, n) > 0 ? 1 : 0);
    end
    wr(4, 8'h03); rd(4, v); chk("R10 clear", v, 0);

    // R2 boundary: wrap from 0xFF to reload
    wr(0, 0); wr(1, 8'hFE); wr(0, 8'h01); ovf_seen = 0;
    ticks(1); rd(2, v); chk("R2 ff", v, 255);
    ticks(1); rd(2, v); chk("R2 wrap", v, 254);
    chk("R3 single pulse", ovf_seen, 1);

    // R4 deferred reload
    wr(0, 0); wr(1, 8'hF0); wr(0, 8'h01);
    ticks(14); wr(1, 8'h10);
    rd(2, v); chk("R4 untouched", v, 8'hFE);
    ticks(1); rd(2, v); chk("R4 ff", v, 8'hFF);
    ticks(1); rd(2, v); chk("R4 new reload", v, 8'h10);

    // R11 stopped
    wr(0, 8'h00); ticks(5); ext_pulse(); rd(2, v); chk("R11 hold", v, 8'h10);

    // R5 external clock, prescale ignored
    wr(1, 8'h00); wr(0, 8'h09);
    @(negedge clk); prescale_tick = 1;
    for (int i = 0; i < 5; i++) ext_pulse();
    @(negedge clk); prescale_tick = 0;
    repeat (4) @(negedge clk);
    rd(2, v); chk("R5 ext edges", v, 5);

    // R6 capture with R9 irq
    wr(0, 0); wr(4, 3); wr(1, 8'h20); wr(0, 8'h23);
    ticks(7);
    @(negedge clk); cap_in = 1; repeat (3) @(negedge clk); cap_in = 0; repeat (4) @(negedge clk);
    rd(3, v); chk("R6 capture", v, 8'h27);
    rd(4, v); chk("R6 flag", v, 2);
    chk("R9 irq cap", irq, 1);
    ticks(3); rd(2, v); chk("R6 continues", v, 8'h2A);

    // R9 masking
    wr(0, 0); wr(4, 3); wr(1, 8'hFF); wr(0, 8'h01); ticks(1);
    chk("R9 masked", irq, 0);
    wr(0, 8'h11); chk("R9 enabled", irq, 1);

    // R10 set wins over clear
    @(negedge clk); wr_en = 1; wr_addr = 4; wr_data = 8'h01; prescale_tick = 1;
    @(negedge clk); wr_en = 0; prescale_tick = 0;
    rd(4, v); chk("R10 set wins", v & 1, 1);
    wr(4, 8'h01); rd(4, v); chk("R10 cleared", v & 1, 0);

    // R7 measurement windows, random edge counts
    for (int t = 0; t < 3; t++) begin
      wr(0, 0); wr(4, 3); wr(0, 8'h05); total = 0;
      for (int w = 0; w < GATE; w++) begin
        n = $urandom % 4; total += n;
        for (int k = 0; k < n; k++) ext_pulse();
        repeat (4) @(negedge clk);
        ticks(1);
      end
      rd(3, v); chk("R7 window count", v, total);
      rd(4, v); chk("R7 flag", v, 2);
      rd(2, v); chk("R7 restart", v, 0);
    end

    // R8 saturation
    wr(0, 0); wr(0, 8'h05); ovf_seen = 0;
    for (int k = 0; k < 300; k++) ext_pulse();
    repeat (4) @(negedge clk);
    ticks(GATE);
    rd(3, v); chk("R8 saturate", v, 255);
    chk("R8 no ovf", ovf_seen, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule